// File: doc/BRIEF.md
# Upper-Memory Shadow and SMRAM Decoder

This block steers every CPU access into the legacy upper-memory area of a PC-style northbridge. For each address it decides whether the cycle is served by internal DRAM or passed to the external bus. It also produces the DRAM address that goes with the decision. Three configuration bytes drive the decision: a shadow region byte, a shadow control byte and an SMM control byte. An SMM status byte supplies the backing-base selector for the relocated SMRAM window.

The configuration bytes are sampled into local registers on every rising clock edge. The access decode is purely combinational from the CPU address, the access kind and those registered bytes. The outputs therefore follow the address in the same cycle and follow a configuration change one edge later. Accesses are plain level signals that are valid in every cycle, so there is no valid/ready pair and no back-pressure.

Top module: `umem_decode`

## Requirements
- R1: While `rst_n` is low, the registered configuration is all zero. All accesses then go to the external bus (`to_dram`=0), `smram_hit`=0, and both BIOS flags are 0.
- R2: Each configuration byte is captured at a rising edge of `clk`. A change to a `*_cfg` input affects the decode only after the next rising edge.
- R3: The range C0000h–DFFFFh consists of eight 16 KB regions. Region i starts at C0000h + i·4000h and is enabled by bit i of `shadow_region_cfg`.
- R4: The range E0000h–FFFFFh consists of four 32 KB regions. Region i starts at E0000h + i·8000h and is enabled by bit i (bits 3:0) of `shadow_ctrl_cfg`.
- R5: In an enabled shadow region, a read (`cpu_write`=0) goes to DRAM only if `shadow_ctrl_cfg` bit 4 is 1. A write goes to DRAM only if bit 5 is 1. Accesses to a disabled region go to the external bus. Accesses outside A0000h–FFFFFh always go to the external bus.
- R6: The SMRAM mode is `smm_ctrl_cfg` bits 5:4, and mode 00 disables the window. Mode 01 maps A0000h–BFFFFh to DRAM at the same address. Mode 10 maps E0000h–EFFFFh to DRAM at the same address. A window hit takes precedence over shadow steering for both reads and writes.
- R7: Mode 11 maps host A8000h–AFFFFh to DRAM. The backing base is 68000h when `smm_status_cfg` bits 7:6 equal 10. For any other value of those bits, the backing base is 38000h. In both cases the address offset is kept.
- R8: The SMRAM window is active only when `smm_active` is 1 or `smm_ctrl_cfg` bit 3 is 1. Otherwise the access is decoded by the shadow rules alone.
- R9: Suppose the mode is 01 and `smm_ctrl_cfg` bit 0 is 1. Then a code fetch (`code_fetch`=1) in A0000h–BFFFFh goes to DRAM at its own address, even when the window is not active. In this case `smram_hit` stays 0.
- R10: `bios_rd_shadow` is 1 exactly when some E-area region is enabled and read steering (bit 4) is on. `bios_wr_shadow` is the same with write steering (bit 5).
- R11: `dram_addr` equals `cpu_addr` except on an SMRAM window hit. On a hit it carries the translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the configuration registers |
| cpu_addr | input | 24 | CPU physical address |
| cpu_write | input | 1 | 1 = write access, 0 = read access |
| code_fetch | input | 1 | Read is an instruction fetch |
| smm_active | input | 1 | CPU is in system management mode |
| shadow_region_cfg | input | 8 | Enable bits of the 16 KB regions |
| shadow_ctrl_cfg | input | 8 | E-area enables (3:0), read steer (4), write steer (5) |
| smm_ctrl_cfg | input | 8 | SMRAM mode (5:4), visible outside SMM (3), code-to-DRAM (0) |
| smm_status_cfg | input | 8 | Backing-base selector in bits 7:6 |
| to_dram | output | 1 | Access is served by internal DRAM |
| dram_addr | output | 24 | DRAM address for the access |
| smram_hit | output | 1 | Access falls in the active SMRAM window |
| bios_rd_shadow | output | 1 | Some E-area region shadows reads |
| bios_wr_shadow | output | 1 | Some E-area region shadows writes |

## Verification
The bench builds the block with its default parameters: a 24-bit address, eight C/D-area regions and four E/F-area regions. With these values every region boundary can be reached, along with addresses above 1 MB that must stay external. Directed probes sit on the first and last byte of each region and each SMRAM window. Every SMRAM mode is tried with each combination of SMM state and the visibility bit. Random addresses concentrated in 90000h–10FFFFh are then mixed with random configuration changes. These random changes exercise the one-edge delay between a configuration input and the decode that uses it.

// File: rtl/umem_pkg.sv
package umem_pkg;
  typedef enum logic [1:0] {
    SMR_OFF   = 2'b00,
    SMR_LOW   = 2'b01,
    SMR_HIGH  = 2'b10,
    SMR_RELOC = 2'b11
  } smr_mode_e;

  localparam logic [31:0] CD_BASE   = 32'h000C_0000;
  localparam logic [31:0] CD_SPAN   = 32'h0002_0000;
  localparam logic [31:0] EF_BASE   = 32'h000E_0000;
  localparam logic [31:0] EF_SPAN   = 32'h0002_0000;
  localparam logic [31:0] VGA_BASE  = 32'h000A_0000;
  localparam logic [31:0] VGA_SPAN  = 32'h0002_0000;
  localparam logic [31:0] EHI_SPAN  = 32'h0001_0000;
  localparam logic [31:0] REL_HOST  = 32'h000A_8000;
  localparam logic [31:0] REL_SPAN  = 32'h0000_8000;
  localparam logic [31:0] REL_BASE_A = 32'h0006_8000;
  localparam logic [31:0] REL_BASE_B = 32'h0003_8000;
endpackage

// File: rtl/umem_shadow_decode.sv
module umem_shadow_decode
  import umem_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int C_REGIONS = 8,
  parameter int E_REGIONS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_write,
  input  logic [C_REGIONS-1:0] c_en,
  input  logic [E_REGIONS-1:0] e_en,
  input  logic                 rd_steer,
  input  logic                 wr_steer,
  output logic                 sh_dram
);
  localparam int C_SH = $clog2(CD_SPAN / C_REGIONS);
  localparam int E_SH = $clog2(EF_SPAN / E_REGIONS);

  logic [31:0] a32, c_off, e_off;
  logic        in_c, in_e, dir_ok;
  logic [C_REGIONS-1:0] c_sel;
  logic [E_REGIONS-1:0] e_sel;

  assign a32   = 32'(addr);
  assign c_off = a32 - CD_BASE;
  assign e_off = a32 - EF_BASE;
  assign in_c  = (a32 >= CD_BASE) && (a32 < CD_BASE + CD_SPAN);
  assign in_e  = (a32 >= EF_BASE) && (a32 < EF_BASE + EF_SPAN);

  for (genvar g = 0; g < C_REGIONS; g++) begin : g_c
    assign c_sel[g] = in_c && ((c_off >> C_SH) == 32'(g));
  end
  for (genvar g = 0; g < E_REGIONS; g++) begin : g_e
    assign e_sel[g] = in_e && ((e_off >> E_SH) == 32'(g));
  end

  assign dir_ok  = is_write ? wr_steer : rd_steer;
  assign sh_dram = (|(c_sel & c_en) || |(e_sel & e_en)) && dir_ok;

  // R3
  cd_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_c && !(|(c_sel & c_en))) |-> !sh_dram);
  // R5
  outside_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_c && !in_e) |-> !sh_dram);
endmodule

// File: rtl/umem_smram_decode.sv
module umem_smram_decode
  import umem_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  smr_mode_e         mode,
  input  logic [1:0]        base_sel,
  input  logic              visible,
  input  logic              keep_code,
  input  logic              code_fetch,
  output logic              hit,
  output logic              code_dram,
  output logic [ADDR_W-1:0] xlat_addr
);
  logic [31:0] a32, lo, span, base;
  logic        in_win, in_vga;

  assign a32 = 32'(addr);

  always_comb begin
    lo   = VGA_BASE;
    span = 32'd0;
    base = VGA_BASE;
    unique case (mode)
      SMR_LOW:   begin lo = VGA_BASE; span = VGA_SPAN; base = VGA_BASE; end
      SMR_HIGH:  begin lo = EF_BASE;  span = EHI_SPAN; base = EF_BASE;  end
      SMR_RELOC: begin
        lo   = REL_HOST;
        span = REL_SPAN;
        base = (base_sel == 2'b10) ? REL_BASE_A : REL_BASE_B;
      end
      default:   begin lo = VGA_BASE; span = 32'd0; base = VGA_BASE; end
    endcase
  end

  assign in_win    = (a32 >= lo) && (a32 < lo + span);
  assign in_vga    = (a32 >= VGA_BASE) && (a32 < VGA_BASE + VGA_SPAN);
  assign hit       = visible && in_win;
  assign xlat_addr = ADDR_W'(base + (a32 - lo));
  assign code_dram = (mode == SMR_LOW) && keep_code && code_fetch && in_vga;

  // R6
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SMR_OFF) |-> !hit);
  // R8
  hidden_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !visible |-> !hit);
  // R11
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (xlat_addr[14:0] == addr[14:0]));
endmodule

// File: rtl/umem_decode.sv
module umem_decode
  import umem_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int C_REGIONS = 8,
  parameter int E_REGIONS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_write,
  input  logic              code_fetch,
  input  logic              smm_active,
  input  logic [7:0]        shadow_region_cfg,
  input  logic [7:0]        shadow_ctrl_cfg,
  input  logic [7:0]        smm_ctrl_cfg,
  input  logic [7:0]        smm_status_cfg,
  output logic              to_dram,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              smram_hit,
  output logic              bios_rd_shadow,
  output logic              bios_wr_shadow
);
  logic [7:0] region_q, sctl_q, smc_q, sts_q;
  logic       sh_dram, smr_hit, code_dram;
  logic [ADDR_W-1:0] xlat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region_q <= '0;
      sctl_q   <= '0;
      smc_q    <= '0;
      sts_q    <= '0;
    end else begin
      region_q <= shadow_region_cfg;
      sctl_q   <= shadow_ctrl_cfg;
      smc_q    <= smm_ctrl_cfg;
      sts_q    <= smm_status_cfg;
    end
  end

  umem_shadow_decode #(.ADDR_W(ADDR_W), .C_REGIONS(C_REGIONS), .E_REGIONS(E_REGIONS)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (cpu_addr),
    .is_write (cpu_write),
    .c_en     (region_q[C_REGIONS-1:0]),
    .e_en     (sctl_q[E_REGIONS-1:0]),
    .rd_steer (sctl_q[4]),
    .wr_steer (sctl_q[5]),
    .sh_dram  (sh_dram)
  );

  umem_smram_decode #(.ADDR_W(ADDR_W)) u_smram (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (cpu_addr),
    .mode       (smr_mode_e'(smc_q[5:4])),
    .base_sel   (sts_q[7:6]),
    .visible    (smm_active | smc_q[3]),
    .keep_code  (smc_q[0]),
    .code_fetch (code_fetch),
    .hit        (smr_hit),
    .code_dram  (code_dram),
    .xlat_addr  (xlat)
  );

  assign smram_hit      = smr_hit;
  assign to_dram        = smr_hit | code_dram | sh_dram;
  assign dram_addr      = smr_hit ? xlat : cpu_addr;
  assign bios_rd_shadow = (|sctl_q[E_REGIONS-1:0]) & sctl_q[4];
  assign bios_wr_shadow = (|sctl_q[E_REGIONS-1:0]) & sctl_q[5];

  // R6
  hit_to_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smram_hit |-> to_dram);
  // R5
  above_meg_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cpu_addr) >= 32'h0010_0000) |-> !to_dram);
  // R2
  bios_wr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bios_wr_shadow |=> ($past(shadow_ctrl_cfg[5]) || !$past(rst_n) || bios_wr_shadow == sctl_q[5]));
endmodule

// File: tb/umem_decode_tb.sv
module umem_decode_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        cpu_write = 1'b0, code_fetch = 1'b0, smm_active = 1'b0;
  logic [7:0]  region_cfg = '0, sctl_cfg = '0, smc_cfg = '0, sts_cfg = '0;
  logic        to_dram, smram_hit, bios_rd_shadow, bios_wr_shadow;
  logic [23:0] dram_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_region = '0, m_sctl = '0, m_smc = '0, m_sts = '0;

  always #4 clk = ~clk;

  umem_decode u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
    .code_fetch(code_fetch), .smm_active(smm_active),
    .shadow_region_cfg(region_cfg), .shadow_ctrl_cfg(sctl_cfg),
    .smm_ctrl_cfg(smc_cfg), .smm_status_cfg(sts_cfg),
    .to_dram(to_dram), .dram_addr(dram_addr), .smram_hit(smram_hit),
    .bios_rd_shadow(bios_rd_shadow), .bios_wr_shadow(bios_wr_shadow)
  );

  // behavioural model of the configuration capture (R2)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_region <= 0; m_sctl <= 0; m_smc <= 0; m_sts <= 0;
    end else begin
      m_region <= region_cfg; m_sctl <= sctl_cfg; m_smc <= smc_cfg; m_sts <= sts_cfg;
    end
  end

  task automatic expect_now(input string req);
    int a, lo, span, base, mode, idx;
    bit vis, e_dram, e_hit, e_rd, e_wr;
    int e_addr;
    a = int'(cpu_addr);
    mode = int'(m_smc[5:4]);
    vis = smm_active || m_smc[3];
    e_hit = 0; e_dram = 0; e_addr = a; span = 0; lo = 0; base = 0;
    if (mode == 1) begin lo = 'hA0000; span = 'h20000; base = 'hA0000; end
    if (mode == 2) begin lo = 'hE0000; span = 'h10000; base = 'hE0000; end
    if (mode == 3) begin
      lo = 'hA8000; span = 'h8000;
      base = (m_sts[7:6] == 2'b10) ? 'h68000 : 'h38000;
    end
    if (vis && span != 0 && a >= lo && a < lo + span) begin
      e_hit = 1; e_dram = 1; e_addr = base + (a - lo);
    end else if (mode == 1 && m_smc[0] && code_fetch && a >= 'hA0000 && a < 'hC0000) begin
      e_dram = 1;
    end else if (a >= 'hC0000 && a < 'hE0000) begin
      idx = (a - 'hC0000) / 'h4000;
      if (m_region[idx]) e_dram = cpu_write ? m_sctl[5] : m_sctl[4];
    end else if (a >= 'hE0000 && a < 'h100000) begin
      idx = (a - 'hE0000) / 'h8000;
      if (m_sctl[idx]) e_dram = cpu_write ? m_sctl[5] : m_sctl[4];
    end
    e_rd = (m_sctl[3:0] != 0) && m_sctl[4];
    e_wr = (m_sctl[3:0] != 0) && m_sctl[5];
    checks++;
    if (to_dram !== e_dram || smram_hit !== e_hit || dram_addr !== 24'(e_addr) ||
        bios_rd_shadow !== e_rd || bios_wr_shadow !== e_wr) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b: got dram=%0b hit=%0b da=%h rd=%0b wr=%0b, exp dram=%0b hit=%0b da=%h rd=%0b wr=%0b",
               req, cpu_addr, cpu_write, to_dram, smram_hit, dram_addr, bios_rd_shadow,
               bios_wr_shadow, e_dram, e_hit, 24'(e_addr), e_rd, e_wr);
    end
  endtask

  task automatic acc(input int a, input bit wr, input bit smm, input bit code, input string req);
    @(negedge clk);
    cpu_addr = 24'(a); cpu_write = wr; smm_active = smm; code_fetch = code;
    #2;
    expect_now(req);
  endtask

  task automatic cfg(input logic [7:0] r, input logic [7:0] s, input logic [7:0] m, input logic [7:0] t);
    @(negedge clk);
    region_cfg = r; sctl_cfg = s; smc_cfg = m; sts_cfg = t;
    #2;
    expect_now("R2");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: configuration inputs set but held in reset
    region_cfg = 8'hFF; sctl_cfg = 8'h3F; smc_cfg = 8'h18; sts_cfg = 8'h80;
    repeat (3) acc('hC0000, 0, 1, 0, "R1");
    acc('hA0000, 0, 1, 0, "R1");
    acc('hE8000, 1, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    region_cfg = 8'h00; sctl_cfg = 8'h00; smc_cfg = 8'h00; sts_cfg = 8'h00;
    // R3: one region at a time, read steering on
    for (int i = 0; i < 8; i++) begin
      cfg(8'(1 << i), 8'h10, 8'h00, 8'h00);
      for (int j = 0; j < 8; j++) begin
        acc('hC0000 + j * 'h4000, 0, 0, 0, "R3");
        acc('hC3FFF + j * 'h4000, 0, 0, 0, "R3");
      end
    end
    // R4, R10
    for (int i = 0; i < 4; i++) begin
      cfg(8'h00, 8'(8'h20 | (1 << i)), 8'h00, 8'h00);
      for (int j = 0; j < 4; j++) begin
        acc('hE0000 + j * 'h8000, 1, 0, 0, "R4");
        acc('hE7FFF + j * 'h8000, 0, 0, 0, "R10");
      end
    end
    // R5: direction steering
    for (int s = 0; s < 4; s++) begin
      cfg(8'hA5, 8'(8'h05 | (s << 4)), 8'h00, 8'h00);
      acc('hC4000, 0, 0, 0, "R5"); acc('hC4000, 1, 0, 0, "R5");
      acc('hC0000, 0, 0, 0, "R5"); acc('hC0000, 1, 0, 0, "R5");
      acc('hF0000, 1, 0, 0, "R5"); acc('hE8000, 0, 0, 0, "R5");
      acc('h9FFFF, 0, 0, 0, "R5"); acc('h1C0000, 1, 0, 0, "R5");
    end
    // R6, R7, R8, R9: SMRAM modes
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 2; v++) begin
        for (int st = 0; st < 4; st++) begin
          cfg(8'hFF, 8'h3F, 8'((m << 4) | (v << 3) | 1), 8'(st << 6));
          acc('hA0000, 1, 1, 0, "R6"); acc('hBFFFF, 0, 0, 0, "R8");
          acc('hA8000, 0, 1, 0, "R7"); acc('hAFFFF, 1, 0, 0, "R7");
          acc('hE0000, 0, 1, 0, "R6"); acc('hEFFFF, 1, 0, 0, "R8");
          acc('hF0000, 0, 1, 0, "R6"); acc('hA7FFF, 0, 1, 0, "R11");
          acc('hB0000, 0, 0, 1, "R9"); acc('hA0000, 0, 0, 1, "R9");
        end
      end
    end
    // random mix, R2 and R11
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0)
        cfg(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      acc(int'($urandom_range('h90000, 'h10FFFF)), 1'($urandom), 1'($urandom),
          1'($urandom), "R11");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule